// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block shapes the loudness of one FM synthesis operator over time. A gate input opens and closes the note. On every sample-enable pulse a phase accumulator moves by an amount that depends on the active rate, and the block reports an attenuation code in 0.1875 dB units. The code 0 means full volume and 511 means silent (about 96 dB down). A done flag marks an operator that has gone fully quiet, so that the voice mixer can skip it.

The envelope has six states: attack, decay, sustain-hold, sustain, release and finished. The attack follows a concave curve that is read from a 16-entry table indexed by the top four bits of the phase. The other states are linear in the phase. Each rate can be sped up by a key-rate value taken from the octave (block) and the top bit of the frequency number, so that higher notes have faster envelopes. A key-on pulses a restart output that tells the oscillator to clear its phase.

Top module: `fm_env_gen`

## Requirements
- R1: After reset the block is finished, with atten = 511, env_done = 1 and osc_restart = 0.
- R2: A high gate while the slot is off starts attack at phase 0, so atten = 511 one cycle later. osc_restart is high for exactly that one cycle. Holding gate high does not retrigger.
- R3: The key-rate value kr is {block, fnum_msb} when ksr_en = 1, and block >> 1 when ksr_en = 0. The effective rate is m = min(rate + kr[3:2], 15) and the fine factor is f = kr[1:0]. The per-step increment in units of 2^-13 atten steps is 3(f+4)<<(m+1) in attack and (f+4)<<(m-1) elsewhere.
- R4: An attack rate of 0 never advances the phase. An attack rate of 15 finishes the attack on the first step.
- R5: During attack, atten is taken from the table {511,386,313,261,221,188,160,136,115,96,79,63,48,35,22,11}, indexed by phase bits [21:18].
- R6: When the attack phase passes 2^22, atten becomes 0 and decay begins with the phase at 0.
- R7: In decay, atten = phase >> 13. Once the phase reaches the sustain target (sus_lvl × 16 steps, where code 15 means 496), the phase is clamped to the target. The block then enters sustain-hold if hold_en = 1, and sustain otherwise.
- R8: Sustain-hold keeps atten constant while hold_en = 1. A step taken with hold_en = 0 moves it to sustain, where the release rate applies.
- R9: A low gate while the slot is on enters release, and atten does not jump. From attack, the current curve level becomes the linear phase. A low gate while the slot is off has no effect.
- R10: Release uses rate_rel when hold_en = 1 and a fixed rate of 7 when hold_en = 0.
- R11: When sustain or release passes full attenuation, the block enters finished with atten = 511 and env_done = 1.
- R12: Without a step pulse or a gate event, the state and atten do not change.
- R13: A decay or release rate of 0 never advances the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Sample enable; advances the envelope once |
| gate | input | 1 | Note gate; a rise keys on, a fall keys off |
| rate_atk | input | 4 | Attack rate |
| rate_dec | input | 4 | Decay rate |
| sus_lvl | input | 4 | Sustain level, 3 dB per code (15 = 93 dB) |
| rate_rel | input | 4 | Release rate |
| hold_en | input | 1 | Sustain-hold mode |
| ksr_en | input | 1 | Key-rate scaling select |
| block | input | 3 | Octave of the note |
| fnum_msb | input | 1 | Top bit of the frequency number |
| atten | output | 9 | Attenuation in 0.1875 dB steps |
| env_done | output | 1 | Envelope finished (silent) |
| osc_restart | output | 1 | One-cycle pulse to clear the oscillator phase |

## Verification
The bench aims at the corners where a slip would be easy to miss:
- **Key-off during attack.** If the curve level were not converted into a linear phase, atten would jump at the key-off.
- **Attack rate 15.** A wrong overflow check would leave the envelope stuck in attack instead of reaching 0 in one step.
- **Sustain code 15.** This code maps to 496 and not 240, so a plain ×16 would clamp at the wrong level.
- **Release rate with hold off.** Using rate_rel instead of the fixed rate 7 would change the release slope by a known amount.
- **Key-rate scaling.** Exact atten values are checked with scaling on and off, including the cap at 15, where a missing cap overshoots.
- **Edge cases.** The bench also checks that a held gate or an idle cycle does not move the envelope.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

  // Attenuation code width: 512 steps of 0.1875 dB cover 96 dB.
  localparam int EG_BITS = 9;
  localparam logic [EG_BITS-1:0] ATT_MAX = '1;

  typedef enum logic [2:0] {
    ST_ATK  = 3'd0,
    ST_DEC  = 3'd1,
    ST_HOLD = 3'd2,
    ST_SUS  = 3'd3,
    ST_REL  = 3'd4,
    ST_FIN  = 3'd5
  } eg_state_e;

  // Key-rate value from the octave and the top frequency bit.
  function automatic logic [3:0] keyrate_of(input logic ksr_en,
                                            input logic [2:0] blk,
                                            input logic fmsb);
    return ksr_en ? {blk, fmsb} : {2'b00, blk[2:1]};
  endfunction

  // Effective rate: register rate plus the coarse key-rate part, capped at 15.
  function automatic logic [3:0] eff_rate(input logic [3:0] rate,
                                          input logic [3:0] kr);
    logic [4:0] sum;
    sum = {1'b0, rate} + {3'b000, kr[3:2]};
    return (sum > 5'd15) ? 4'd15 : sum[3:0];
  endfunction

  // Concave attack shape, indexed by the top four phase bits.
  function automatic logic [EG_BITS-1:0] attack_shape(input logic [3:0] idx);
    case (idx)
      4'd0:  return 9'd511;
      4'd1:  return 9'd386;
      4'd2:  return 9'd313;
      4'd3:  return 9'd261;
      4'd4:  return 9'd221;
      4'd5:  return 9'd188;
      4'd6:  return 9'd160;
      4'd7:  return 9'd136;
      4'd8:  return 9'd115;
      4'd9:  return 9'd96;
      4'd10: return 9'd79;
      4'd11: return 9'd63;
      4'd12: return 9'd48;
      4'd13: return 9'd35;
      4'd14: return 9'd22;
      default: return 9'd11;
    endcase
  endfunction

  // Sustain target in attenuation steps: 16 steps per 3 dB, code 15 is 93 dB.
  function automatic logic [EG_BITS-1:0] sustain_steps(input logic [3:0] code);
    return (code == 4'd15) ? 9'd496 : {1'b0, code, 4'b0000};
  endfunction

endpackage

// File: rtl/eg_rate_unit.sv
module eg_rate_unit
  import fm_env_pkg::*;
#(
  parameter int PH_W = 23
) (
  input  eg_state_e        st,
  input  logic [3:0]       rate_atk,
  input  logic [3:0]       rate_dec,
  input  logic [3:0]       rate_rel,
  input  logic             hold_en,
  input  logic [3:0]       kr,
  output logic [PH_W-1:0]  inc
);
  localparam logic [3:0] FALLBACK_REL = 4'd7;
  localparam logic [PH_W-1:0] INSTANT = {1'b1, {(PH_W-1){1'b0}}};

  logic [3:0] sel_rate;
  logic       is_atk;
  logic [3:0] rm;
  logic [1:0] fine;
  logic [4:0] atk_base;
  logic [2:0] lin_base;

  always_comb begin
    is_atk = 1'b0;
    case (st)
      ST_ATK:  begin sel_rate = rate_atk; is_atk = 1'b1; end
      ST_DEC:  sel_rate = rate_dec;
      ST_SUS:  sel_rate = rate_rel;
      ST_REL:  sel_rate = hold_en ? rate_rel : FALLBACK_REL;
      default: sel_rate = 4'd0;
    endcase
  end

  assign rm       = eff_rate(sel_rate, kr);
  assign fine     = kr[1:0];
  assign atk_base = 5'd3 * ({3'b000, fine} + 5'd4);
  assign lin_base = {1'b0, fine} + 3'd4;

  always_comb begin
    if (sel_rate == 4'd0)
      inc = '0;
    else if (is_atk && sel_rate == 4'd15)
      inc = INSTANT;
    else if (is_atk)
      inc = PH_W'(atk_base) << ({1'b0, rm} + 5'd1);
    else
      inc = PH_W'(lin_base) << ({1'b0, rm} - 5'd1);
  end
endmodule

// File: rtl/eg_attack_curve.sv
module eg_attack_curve
  import fm_env_pkg::*;
#(
  parameter int PH_W = 23
) (
  input  logic [PH_W-1:0]    phase,
  output logic [EG_BITS-1:0] level
);
  logic [3:0] idx;
  assign idx   = phase[PH_W-2 -: 4];
  assign level = attack_shape(idx);
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
#(
  parameter int FRAC_BITS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       gate,
  input  logic [3:0] rate_atk,
  input  logic [3:0] rate_dec,
  input  logic [3:0] sus_lvl,
  input  logic [3:0] rate_rel,
  input  logic       hold_en,
  input  logic       ksr_en,
  input  logic [2:0] block,
  input  logic       fnum_msb,
  output logic [8:0] atten,
  output logic       env_done,
  output logic       osc_restart
);
  // FRAC_BITS must be at least 12 so that the largest increment fits.
  localparam int PH_W = EG_BITS + FRAC_BITS + 1;
  localparam logic [PH_W-1:0] PH_TOP = {1'b0, {(PH_W-1){1'b1}}};

  eg_state_e       st_q, st_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            slot_on_q, slot_on_d;
  logic            restart_q, restart_d;

  // Named events for the checker.
  logic key_on_evt, key_off_evt, key_evt;
  logic [3:0]         kr;
  logic [PH_W-1:0]    inc, ph_sum, sl_ph;
  logic [EG_BITS-1:0] atk_level;

  assign key_on_evt  = gate & ~slot_on_q;
  assign key_off_evt = ~gate & slot_on_q;
  assign key_evt     = key_on_evt | key_off_evt;
  assign kr          = keyrate_of(ksr_en, block, fnum_msb);
  assign ph_sum      = phase_q + inc;
  assign sl_ph       = PH_W'(sustain_steps(sus_lvl)) << FRAC_BITS;

  eg_rate_unit #(.PH_W(PH_W)) u_rate (
    .st(st_q), .rate_atk(rate_atk), .rate_dec(rate_dec), .rate_rel(rate_rel),
    .hold_en(hold_en), .kr(kr), .inc(inc)
  );

  eg_attack_curve #(.PH_W(PH_W)) u_curve (
    .phase(phase_q), .level(atk_level)
  );

  always_comb begin
    st_d      = st_q;
    phase_d   = phase_q;
    slot_on_d = slot_on_q;
    restart_d = 1'b0;
    if (key_on_evt) begin
      st_d      = ST_ATK;
      phase_d   = '0;
      slot_on_d = 1'b1;
      restart_d = 1'b1;
    end else if (key_off_evt) begin
      slot_on_d = 1'b0;
      st_d      = ST_REL;
      if (st_q == ST_ATK)
        phase_d = PH_W'(atk_level) << FRAC_BITS;
    end else if (step) begin
      case (st_q)
        ST_ATK: begin
          if (ph_sum[PH_W-1]) begin
            phase_d = '0;
            st_d    = ST_DEC;
          end else begin
            phase_d = ph_sum;
          end
        end
        ST_DEC: begin
          if (ph_sum >= sl_ph) begin
            phase_d = sl_ph;
            st_d    = hold_en ? ST_HOLD : ST_SUS;
          end else begin
            phase_d = ph_sum;
          end
        end
        ST_HOLD: begin
          if (!hold_en) st_d = ST_SUS;
        end
        ST_SUS, ST_REL: begin
          if (ph_sum[PH_W-1]) begin
            phase_d = PH_TOP;
            st_d    = ST_FIN;
          end else begin
            phase_d = ph_sum;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_FIN;
      phase_q   <= PH_TOP;
      slot_on_q <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      phase_q   <= phase_d;
      slot_on_q <= slot_on_d;
      restart_q <= restart_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_FIN:  atten = ATT_MAX;
      ST_ATK:  atten = atk_level;
      default: atten = phase_q[PH_W-2 -: EG_BITS];
    endcase
  end

  assign env_done    = (st_q == ST_FIN);
  assign osc_restart = restart_q;
endmodule

// File: rtl/fm_env_checker.sv
module fm_env_checker
  import fm_env_pkg::*;
#(
  parameter int PH_W = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic            hold_en,
  input logic [3:0]      rate_atk,
  input logic [8:0]      atten,
  input logic            env_done,
  input logic            osc_restart,
  input eg_state_e       st,
  input logic [PH_W-1:0] phase,
  input logic            key_evt
);
  a_r11_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    env_done |-> atten == 9'd511);

  a_r2_restart_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    osc_restart |-> (st == ST_ATK && atten == 9'd511));

  a_r12_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !key_evt) |=> ($stable(phase) && $stable(st)));

  a_r4_atk_rate0_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ATK && rate_atk == 4'd0 && step && !key_evt) |=> (st == ST_ATK && $stable(phase)));

  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && hold_en && step && !key_evt) |=> (st == ST_HOLD && $stable(atten)));

  a_r6_attack_exit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEC && $past(st) == ST_ATK) |-> atten == 9'd0);
endmodule

bind fm_env_gen fm_env_checker #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .hold_en(hold_en), .rate_atk(rate_atk),
  .atten(atten), .env_done(env_done), .osc_restart(osc_restart),
  .st(st_q), .phase(phase_q), .key_evt(key_evt)
);

// File: tb/fm_env_gen_bench.sv
module fm_env_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC = 13;
  localparam longint FULL = 64'd1 << 22;

  logic clk = 0, rst_n = 0, step = 0, gate = 0;
  logic [3:0] rate_atk = 0, rate_dec = 0, sus_lvl = 0, rate_rel = 0;
  logic hold_en = 0, ksr_en = 0, fnum_msb = 0;
  logic [2:0] block = 0;
  logic [8:0] atten;
  logic env_done, osc_restart;

  int checks = 0, failures = 0, cycles = 0;

  fm_env_gen u_fm_env_gen (
    .clk(clk), .rst_n(rst_n), .step(step), .gate(gate), .rate_atk(rate_atk),
    .rate_dec(rate_dec), .sus_lvl(sus_lvl), .rate_rel(rate_rel), .hold_en(hold_en),
    .ksr_en(ksr_en), .block(block), .fnum_msb(fnum_msb), .atten(atten),
    .env_done(env_done), .osc_restart(osc_restart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: 0 atk, 1 dec, 2 hold, 3 sus, 4 rel, 5 fin.
  int m_st = 5;
  longint m_ph = FULL - 1;
  bit m_on = 0, m_rst = 0;

  function automatic int curve(input int i);
    int t [16] = '{511,386,313,261,221,188,160,136,115,96,79,63,48,35,22,11};
    return t[i];
  endfunction

  function automatic longint m_inc(input int rate, input bit atk);
    int kr, m, f;
    kr = ksr_en ? (int'(block) * 2 + int'(fnum_msb)) : (int'(block) / 2);
    m = rate + kr / 4;
    if (m > 15) m = 15;
    f = kr % 4;
    if (rate == 0) return 0;
    if (atk && rate == 15) return FULL;
    if (atk) return longint'(3 * (f + 4)) << (m + 1);
    return longint'(f + 4) << (m - 1);
  endfunction

  function automatic int m_atten();
    if (m_st == 5) return 511;
    if (m_st == 0) return curve(int'(m_ph >> 18));
    return int'(m_ph >> FRAC);
  endfunction

  task automatic model_upd(input bit g, input bit s);
    longint tgt;
    m_rst = 0;
    if (g && !m_on) begin
      m_on = 1; m_st = 0; m_ph = 0; m_rst = 1;
    end else if (!g && m_on) begin
      m_on = 0;
      if (m_st == 0) m_ph = longint'(curve(int'(m_ph >> 18))) << FRAC;
      m_st = 4;
    end else if (s) begin
      case (m_st)
        0: begin
          m_ph += m_inc(int'(rate_atk), 1);
          if (m_ph >= FULL) begin m_ph = 0; m_st = 1; end
        end
        1: begin
          tgt = longint'((sus_lvl == 15) ? 496 : int'(sus_lvl) * 16) << FRAC;
          m_ph += m_inc(int'(rate_dec), 0);
          if (m_ph >= tgt) begin m_ph = tgt; m_st = hold_en ? 2 : 3; end
        end
        2: if (!hold_en) m_st = 3;
        3, 4: begin
          m_ph += m_inc((m_st == 4 && !hold_en) ? 7 : int'(rate_rel), 0);
          if (m_ph >= FULL) begin m_ph = FULL - 1; m_st = 5; end
        end
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit g, input bit s);
    @(negedge clk);
    gate = g; step = s;
    @(posedge clk);
    model_upd(g, s);
    #1;
  endtask

  task automatic chk_model(input string req);
    chk(atten == m_atten(), req, atten, m_atten());
  endtask

  task automatic retrigger(input logic [3:0] ar);
    rate_atk = ar;
    cyc(0, 0);
    cyc(1, 0);
  endtask

  task automatic t_reset();
    chk(atten == 511, "R1 atten", atten, 511);
    chk(env_done == 1, "R1 done", env_done, 1);
    chk(osc_restart == 0, "R1 restart", osc_restart, 0);
    cyc(0, 1);
    chk(atten == 511 && osc_restart == 0, "R9 gate low while off", atten, 511);
  endtask

  task automatic t_keyon();
    rate_atk = 0;
    cyc(1, 0);
    chk(osc_restart == 1, "R2 restart pulse", osc_restart, 1);
    chk(atten == 511, "R2 attack start", atten, 511);
    chk(env_done == 0, "R2 not done", env_done, 0);
    cyc(1, 0);
    chk(osc_restart == 0, "R2 single pulse", osc_restart, 0);
    for (int i = 0; i < 20; i++) begin
      cyc(1, 1);
      chk(atten == 511 && osc_restart == 0, "R4 attack rate 0", atten, 511);
    end
  endtask

  task automatic t_full_envelope();
    ksr_en = 0; block = 0; fnum_msb = 0;
    retrigger(4'd10);
    for (int i = 0; i < 400 && m_st == 0; i++) begin
      cyc(1, 1);
      chk_model("R5 attack curve");
    end
    chk(atten == 0 && m_st == 1, "R6 attack end", atten, 0);
    rate_dec = 12; sus_lvl = 2; hold_en = 1;
    for (int i = 0; i < 400 && m_st == 1; i++) begin
      cyc(1, 1);
      chk_model("R7 decay");
    end
    chk(atten == 32, "R7 sustain target", atten, 32);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1);
      chk(atten == 32, "R8 hold", atten, 32);
    end
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0);
      chk(atten == 32, "R12 no step", atten, 32);
    end
    hold_en = 0; rate_rel = 12;
    cyc(1, 1);
    chk(atten == 32, "R8 hold exit", atten, 32);
    for (int i = 0; i < 2000 && m_st != 5; i++) begin
      cyc(1, 1);
      chk_model("R8 sustain at release rate");
    end
    chk(atten == 511 && env_done == 1, "R11 finished", atten, 511);
  endtask

  task automatic t_instant_and_ksr();
    ksr_en = 1; block = 7; fnum_msb = 1; hold_en = 1; sus_lvl = 15; rate_dec = 13;
    retrigger(4'd15);
    cyc(1, 1);
    chk(atten == 0, "R4 attack rate 15", atten, 0);
    cyc(1, 1);
    chk(atten == 14, "R3 keyrate on capped", atten, 14);
    for (int i = 0; i < 100 && m_st == 1; i++) cyc(1, 1);
    chk(atten == 496, "R7 sustain code 15", atten, 496);
    ksr_en = 0;
    retrigger(4'd15);
    cyc(1, 1);
    cyc(1, 1);
    cyc(1, 1);
    chk(atten == 7, "R3 keyrate off", atten, 7);
    rate_dec = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1, 1);
      chk(atten == 7, "R13 decay rate 0", atten, 7);
    end
  endtask

  task automatic t_keyoff_attack();
    int lvl;
    ksr_en = 0; block = 0; fnum_msb = 0; hold_en = 0; rate_rel = 15;
    retrigger(4'd8);
    for (int i = 0; i < 200; i++) cyc(1, 1);
    lvl = atten;
    chk(lvl < 511 && lvl > 0, "R5 mid attack", lvl, m_atten());
    cyc(0, 0);
    chk(atten == lvl, "R9 keyoff no jump", atten, lvl);
    for (int i = 0; i < 32; i++) cyc(0, 1);
    chk(atten == lvl + 1, "R10 fallback rate 7", atten, lvl + 1);
    hold_en = 1;
    cyc(0, 1);
    chk(atten == lvl + 9, "R10 release rate with hold", atten, lvl + 9);
    rate_rel = 0;
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1);
      chk(atten == lvl + 9, "R13 release rate 0", atten, lvl + 9);
    end
    rate_rel = 15;
    for (int i = 0; i < 200 && m_st != 5; i++) begin
      cyc(0, 1);
      chk_model("R10 release");
    end
    chk(env_done == 1 && atten == 511, "R11 release end", atten, 511);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_keyon();
    t_full_envelope();
    t_instant_and_ksr();
    t_keyoff_attack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule